// File: doc/BRIEF.md
# Event Input Timestamp Capture

This block watches one external event pin. The pin is first brought into the clock domain and then filtered. A filtered edge of the chosen polarity is a qualifying event when capture is armed. On such an event the block copies the live seconds-through-year time vector into a capture register, sets a sticky event flag and requests an interrupt.

Capture works in one of two modes. In single-shot mode the arm bit clears itself after the first timestamp. In repeat mode every later event overwrites the stored time. The interrupt request is a level: it stays active while the flag is set and the interrupt enable is on. It drops in the cycle after software clears either one. The block's request is ORed with the requests of the other interrupt sources to drive one shared active-low open-drain line. The `int_pull_low` output means "pull the line low"; when it is 0 the line is released.

Software writes the control fields with a single write strobe. The flag is cleared with its own strobe. The pull-up enable bit is only stored and presented on an output.

Top module: `evt_stamp`

## Requirements
- R1: Control bit `cfg_rise` selects the active edge of the filtered pin: 0 = falling, 1 = rising. An edge of the other polarity captures nothing and leaves the flag unchanged.
- R2: With `cfg_repeat` = 0, the arm bit clears itself in the cycle after a timestamp is taken. Later edges then neither capture nor set the flag until software arms again.
- R3: With `cfg_repeat` = 1, every qualifying event overwrites `cap_time` with the value of `time_now` in the cycle the edge is detected, and the arm bit stays set.
- R4: A qualifying event sets `evt_flag`. The flag stays 1 until a `flag_clr` pulse. If an event and `flag_clr` fall in the same cycle, the event wins.
- R5: With the interrupt enable set, a set flag drives `int_pull_low` to 1. It stays 1 for as long as the flag is 1; there is no automatic release.
- R6: Clearing the flag, or writing 0 to the interrupt enable, releases `int_pull_low` in the very next cycle, unless another source is requesting.
- R7: With the interrupt enable at 0, an event still sets the flag and captures, but `int_pull_low` stays 0.
- R8: `int_pull_low` is the OR of this block's request and every bit of `other_req`. Releasing this block's request does not release the line while any other request is active.
- R9: `pin_mon` shows the current filtered level of the event pin. It reads 1 after reset.
- R10: Filter field `cfg_filt` = 0 passes the synchronised level without filtering. A value n from 1 to 3 requires the new level to be seen on 2^n consecutive `tick` pulses before it is accepted. Shorter pulses change neither `pin_mon` nor the flag.
- R11: While disarmed, edges of the active polarity leave `cap_time` and `evt_flag` unchanged.
- R12: `pullup_en` returns the last value written through `cfg_pullup` and has no other effect. It reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Filter sampling strobe |
| evt_pin | input | 1 | Asynchronous external event pin |
| time_now | input | TIME_W | Live time vector, seconds through year |
| cfg_wr | input | 1 | Write strobe for all control fields |
| cfg_rise | input | 1 | Edge select: 0 falling, 1 rising |
| cfg_arm | input | 1 | Capture enable value to write |
| cfg_repeat | input | 1 | Repeat capture mode |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_pullup | input | 1 | Pull-up enable, stored only |
| cfg_filt | input | 2 | Filter time field |
| flag_clr | input | 1 | Software clear of the event flag |
| other_req | input | OTHER_N | Active-high requests from the other interrupt sources |
| cap_time | output | TIME_W | Captured timestamp |
| arm | output | 1 | Current capture enable state |
| evt_flag | output | 1 | Sticky event flag |
| pin_mon | output | 1 | Filtered pin level |
| pullup_en | output | 1 | Stored pull-up enable |
| int_pull_low | output | 1 | 1 = pull the shared interrupt line low |

## Verification
The embedded properties check on every cycle that the flag holds until cleared, that a flag clear takes effect in the next cycle, and that a single-shot capture disarms. They also check that a captured value equals the time of the edge cycle, that a disarmed block never changes its timestamp, that the filtered level moves only on a tick when filtering is on, and that any active request pulls the line. Only the bench's scenarios can show edge polarity selection, rejection of pulses shorter than the filter window, and the sequence of single-shot and repeat captures against a model.

// File: rtl/evt_stamp.sv
module evt_stamp #(
  parameter int TIME_W = 48,
  parameter int CNT_W = 4,
  parameter int OTHER_N = 3,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               evt_pin,
  input  logic [TIME_W-1:0]  time_now,
  input  logic               cfg_wr,
  input  logic               cfg_rise,
  input  logic               cfg_arm,
  input  logic               cfg_repeat,
  input  logic               cfg_irq_en,
  input  logic               cfg_pullup,
  input  logic [1:0]         cfg_filt,
  input  logic               flag_clr,
  input  logic [OTHER_N-1:0] other_req,
  output logic [TIME_W-1:0]  cap_time,
  output logic               arm,
  output logic               evt_flag,
  output logic               pin_mon,
  output logic               pullup_en,
  output logic               int_pull_low
);

  logic             rise_q, repeat_q, irq_en_q;
  logic [1:0]       filt_q;
  logic [1:0]       sync_q;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need;
  logic             edge_seen, qual;

  assign need      = (filt_q == 2'd0) ? '0 : (CNT_W'(1) << filt_q);
  assign edge_seen = (lvl_q != lvl_d) && (lvl_q == rise_q);
  assign qual      = edge_seen && arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q    <= 1'b0;
      repeat_q  <= 1'b0;
      irq_en_q  <= 1'b0;
      filt_q    <= 2'd0;
      pullup_en <= 1'b0;
    end else if (cfg_wr) begin
      rise_q    <= cfg_rise;
      repeat_q  <= cfg_repeat;
      irq_en_q  <= cfg_irq_en;
      filt_q    <= cfg_filt;
      pullup_en <= cfg_pullup;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{IDLE_LVL}};
      lvl_q  <= IDLE_LVL;
      lvl_d  <= IDLE_LVL;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], evt_pin};
      lvl_d  <= lvl_q;
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (filt_q == 2'd0) begin
        lvl_q <= sync_q[1];
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q + CNT_W'(1) == need) begin
          lvl_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm      <= 1'b0;
      evt_flag <= 1'b0;
      cap_time <= '0;
    end else begin
      if (cfg_wr)                 arm <= cfg_arm;
      else if (qual && !repeat_q) arm <= 1'b0;
      if (qual)          evt_flag <= 1'b1;
      else if (flag_clr) evt_flag <= 1'b0;
      if (qual) cap_time <= time_now;
    end
  end

  assign pin_mon      = lvl_q;
  assign int_pull_low = (evt_flag && irq_en_q) || (|other_req);

  a_r2_single_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !repeat_q && !cfg_wr) |=> !arm);
  a_r3_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> (cap_time == $past(time_now)));
  a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !flag_clr) |=> evt_flag);
  a_r5_int_held: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && irq_en_q) |-> int_pull_low);
  a_r6_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !qual) |=> !evt_flag);
  a_r8_or_sources: assert property (@(posedge clk) disable iff (!rst_n)
    (|other_req) |-> int_pull_low);
  a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != 2'd0 && !tick) |=> $stable(pin_mon));
  a_r11_disarmed_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(cap_time));

endmodule

// File: tb/tb_evt_stamp.sv
`timescale 1ns/1ps
module tb_evt_stamp;
  localparam int TW = 48;
  logic clk = 0, rst_n = 0, tick = 0, evt_pin = 1;
  logic [TW-1:0] time_now = '0;
  logic cfg_wr = 0, cfg_rise = 0, cfg_arm = 0, cfg_repeat = 0, cfg_irq_en = 0, cfg_pullup = 0;
  logic [1:0] cfg_filt = 0;
  logic flag_clr = 0;
  logic [2:0] other_req = 0;
  logic [TW-1:0] cap_time;
  logic arm, evt_flag, pin_mon, pullup_en, int_pull_low;

  evt_stamp dut (.*);

  always #2 clk = ~clk;
  int tcnt = 0;
  always @(negedge clk) begin tcnt <= tcnt + 1; tick <= ((tcnt % 4) == 3); end

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_rise, m_arm, m_rep, m_ien, m_pu, m_flag, m_lvl = 1;
  logic [1:0] m_filt;
  logic [TW-1:0] m_cap = '0;

  function automatic int need_ticks(logic [1:0] f);
    return (f == 0) ? 0 : (1 << f);
  endfunction
  function automatic bit exp_int();
    return (m_flag && m_ien) || (|other_req);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " flag"}, evt_flag, m_flag);
    check({req, " cap"}, cap_time, m_cap);
    check({req, " arm"}, arm, m_arm);
    check({req, " pin_mon R9"}, pin_mon, m_lvl);
    check({req, " int"}, int_pull_low, exp_int());
  endtask

  task automatic wr_cfg(bit r, bit a, bit rp, bit ie, bit pu, logic [1:0] f);
    @(negedge clk);
    cfg_wr = 1; cfg_rise = r; cfg_arm = a; cfg_repeat = rp;
    cfg_irq_en = ie; cfg_pullup = pu; cfg_filt = f;
    @(negedge clk);
    cfg_wr = 0;
    m_rise = r; m_arm = a; m_rep = rp; m_ien = ie; m_pu = pu; m_filt = f;
  endtask

  task automatic set_pin(bit v);
    @(negedge clk);
    time_now = {$urandom, $urandom};
    evt_pin = v;
    repeat (4 * need_ticks(m_filt) + 12) @(negedge clk);
    if (v != m_lvl && v == m_rise && m_arm) begin
      m_flag = 1; m_cap = time_now;
      if (!m_rep) m_arm = 0;
    end
    m_lvl = v;
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    m_flag = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset pin_mon", pin_mon, 1);
    check("R4 reset flag", evt_flag, 0);
    check("R12 reset pullup", pullup_en, 0);
    check("R5 reset int", int_pull_low, 0);
    m_filt = 0;

    wr_cfg(0, 1, 0, 1, 1, 0);
    check("R12 pullup stored", pullup_en, 1);
    set_pin(0); check_all("R1/R2/R5 falling single");
    set_pin(1); check_all("R1 wrong edge");
    set_pin(0); check_all("R11 disarmed");
    clr_flag(); check("R6 flag clear releases", int_pull_low, 0);
    check_all("R6");

    wr_cfg(1, 1, 1, 0, 0, 0);
    check("R12 pullup cleared", pullup_en, 0);
    set_pin(1); check_all("R3/R7 first");
    check("R7 flag no int", int_pull_low, 0);
    set_pin(0); set_pin(1); check_all("R3 overwrite");
    wr_cfg(1, 1, 1, 1, 0, 0); check("R5 enable raises", int_pull_low, 1);
    wr_cfg(1, 1, 1, 0, 0, 0); check("R6 disable releases", int_pull_low, 0);

    wr_cfg(1, 1, 1, 1, 0, 0);
    other_req = 3'b010;
    clr_flag(); check("R8 other holds line", int_pull_low, 1);
    other_req = 0; @(negedge clk);
    check("R8 released", int_pull_low, 0);

    for (int f = 1; f < 4; f++) begin
      wr_cfg(1, 1, 1, 1, 0, f[1:0]);
      @(negedge clk); evt_pin = 0;
      repeat (4 * (need_ticks(f[1:0]) - 1) - 2) @(negedge clk);
      evt_pin = 1;
      repeat (4 * need_ticks(f[1:0]) + 12) @(negedge clk);
      check_all("R10 glitch rejected");
      set_pin(0); set_pin(1); check_all("R10 long pulse accepted");
      clr_flag();
    end

    for (int i = 0; i < 120; i++) begin
      if ($urandom % 4 == 0)
        wr_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4);
      if ($urandom % 5 == 0) clr_flag();
      other_req = ($urandom % 6 == 0) ? 3'b001 : 3'b000;
      set_pin($urandom % 2);
      check_all("R1-random R4 R5 R8");
      check("R12 random", pullup_en, m_pu);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule